// File: doc/BRIEF.md
# SHA-256 Chunk Engine

This block computes a SHA-256 digest over a message that has already been padded and placed in an external 32-bit word memory. A caller gives the number of 512-bit chunks and a one-cycle start pulse. The engine then reads each chunk's sixteen words itself through a synchronous read port with one cycle of latency. For each chunk it builds the message schedule in a sliding 16-word window, runs the 64 compression rounds, and folds the result into the running hash state.

When the last chunk has been folded in, the engine raises a one-cycle done pulse. The 256-bit digest stays on its output until the next accepted start. Message reception, padding, the memory and any serial output are handled by neighbouring blocks.

Top module: `sha_chunk_engine`

## Requirements
- R1: While and right after reset, `done` and `rd_en` are low and `digest` is all zero.
- R2: For a one-chunk message, the digest is the SHA-256 hash of the 512-bit block made of words 0..15. The word at the lowest address is the most significant, and hash word H0 appears on `digest[255:224]` down to H7 on `digest[31:0]`.
- R3: A message of N chunks (1 <= N <= 64) is hashed with chunk k taken from addresses 16k..16k+15. The hash state carries from each chunk into the next.
- R4: During a run, `rd_en` is high for exactly 16N cycles. The addresses are consecutive, run from 0 to 16N-1, and are never at or beyond 16N. The word for an address is taken from `rd_data` on the cycle after the one in which `rd_en` presented it.
- R5: `done` is high in the cycle that follows the clock edge 82N cycles after the edge that accepted `start`. Each chunk takes 17 cycles of fetch, 64 rounds and 1 add.
- R6: `done` is a single-cycle pulse, given once per accepted start.
- R7: After `done`, `digest` holds its value until a new start is accepted.
- R8: A `start` pulse that arrives while a run is in progress (up to and including the done cycle) is ignored. The run completes with its original chunk count and result.
- R9: A `start` with a chunk count of 0 or above 64 is ignored: no reads are made, no `done` is raised, and `digest` is unchanged.
- R10: Every accepted start reloads the eight standard initial hash values, so no state from an earlier run leaks into the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse, sampled while idle |
| chunk_count | input | 7 | Number of 512-bit chunks in the message |
| rd_en | output | 1 | Memory read enable |
| rd_addr | output | 10 | Memory word address |
| rd_data | input | 32 | Memory read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle completion pulse |
| digest | output | 256 | Hash result, H0 in the top word |

## Verification
The bench aims at the places where a chunk engine tends to slip.

- **Read latency.** A design that captured `rd_data` in the same cycle as `rd_en` would shift every word by one and produce a wrong digest.
- **Word order.** Reversed word order within the window gives a wrong digest even on the standard single-block vectors.
- **Chaining.** Resetting the hash state between chunks, instead of carrying it, breaks every multi-chunk result, including the full 64-chunk message that reaches the top address 1023.
- **Control corners.** Stray starts mid-run, counts of 0 and 65, and a rerun after a long message catch designs that restart, that read with a bad count, or that keep the old state. A round counter or fetch counter off by one shows up as a wrong done latency or a wrong read count.

// File: rtl/sha_eng_pkg.sv
package sha_eng_pkg;

  localparam int WORD_W     = 32;
  localparam int WIN_LEN    = 16;
  localparam int ROUNDS     = 64;
  localparam int HASH_WORDS = 8;
  localparam int DIGEST_W   = WORD_W * HASH_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ROUND,
    ST_ADD,
    ST_DONE
  } eng_state_t;

  localparam word_t K_TAB [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam word_t IV_TAB [HASH_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  // Rotate right by a fixed amount.
  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  // Compression sigma on the a lane.
  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  // Compression sigma on the e lane.
  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  // Schedule sigma applied to the word fifteen back.
  function automatic word_t sml_sig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  // Schedule sigma applied to the word two back.
  function automatic word_t sml_sig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t choose(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majority(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction

  function automatic word_t round_k(input logic [5:0] idx);
    return K_TAB[idx];
  endfunction

endpackage

// File: rtl/sha_eng_ctrl.sv
module sha_eng_ctrl
  import sha_eng_pkg::*;
#(
  parameter int MAX_CHUNKS = 64,
  localparam int CHUNK_W = $clog2(MAX_CHUNKS),
  localparam int CNT_W   = CHUNK_W + 1,
  localparam int WIN_W   = $clog2(WIN_LEN),
  localparam int RND_W   = $clog2(ROUNDS),
  localparam int ADDR_W  = CHUNK_W + WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  chunk_count,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              cap_en,
  output logic              load_vars,
  output logic              round_en,
  output logic [RND_W-1:0]  round_idx,
  output logic              add_en,
  output logic              init_hash,
  output logic              done,
  output logic              idle,
  output logic              fetch_done,
  output logic              round_last,
  output logic              chunk_last,
  output logic [CNT_W-1:0]  chunks_o
);

  eng_state_t          state_q;
  logic [CNT_W-1:0]    chunks_q;
  logic [CHUNK_W-1:0]  chunk_idx_q;
  logic [WIN_W:0]      issue_q;
  logic [WIN_W-1:0]    cap_q;
  logic                pend_q;
  logic [RND_W-1:0]    rnd_q;
  logic                count_ok;
  logic                accept;

  assign idle       = (state_q == ST_IDLE);
  assign count_ok   = (chunk_count != '0) && (chunk_count <= CNT_W'(MAX_CHUNKS));
  assign accept     = idle && start && count_ok;
  assign init_hash  = accept;

  assign rd_en      = (state_q == ST_FETCH) && !issue_q[WIN_W];
  assign rd_addr    = {chunk_idx_q, issue_q[WIN_W-1:0]};
  assign cap_en     = pend_q;
  assign fetch_done = (state_q == ST_FETCH) && pend_q && (cap_q == WIN_W'(WIN_LEN - 1));
  assign load_vars  = fetch_done;

  assign round_en   = (state_q == ST_ROUND);
  assign round_idx  = rnd_q;
  assign round_last = round_en && (rnd_q == RND_W'(ROUNDS - 1));
  assign add_en     = (state_q == ST_ADD);
  assign chunk_last = ({1'b0, chunk_idx_q} == (chunks_q - CNT_W'(1)));
  assign done       = (state_q == ST_DONE);
  assign chunks_o   = chunks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      chunks_q    <= '0;
      chunk_idx_q <= '0;
      issue_q     <= '0;
      cap_q       <= '0;
      pend_q      <= 1'b0;
      rnd_q       <= '0;
    end else begin
      pend_q <= rd_en;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q     <= ST_FETCH;
            chunks_q    <= chunk_count;
            chunk_idx_q <= '0;
            issue_q     <= '0;
            cap_q       <= '0;
          end
        end
        ST_FETCH: begin
          if (rd_en)  issue_q <= issue_q + (WIN_W+1)'(1);
          if (pend_q) cap_q   <= cap_q + WIN_W'(1);
          if (fetch_done) begin
            state_q <= ST_ROUND;
            rnd_q   <= '0;
          end
        end
        ST_ROUND: begin
          rnd_q <= rnd_q + RND_W'(1);
          if (round_last) state_q <= ST_ADD;
        end
        ST_ADD: begin
          if (chunk_last) begin
            state_q <= ST_DONE;
          end else begin
            chunk_idx_q <= chunk_idx_q + CHUNK_W'(1);
            issue_q     <= '0;
            cap_q       <= '0;
            state_q     <= ST_FETCH;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sha_msg_sched.sv
module sha_msg_sched
  import sha_eng_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap_en,
  input  word_t cap_word,
  input  logic  round_en,
  output word_t w_cur
);

  word_t win_q [WIN_LEN];
  word_t next_w;
  logic  shift;

  // Window slot j holds W[t+j] while round t runs.
  assign next_w = sml_sig1(win_q[WIN_LEN-2]) + win_q[WIN_LEN-7]
                + sml_sig0(win_q[1]) + win_q[0];
  assign shift  = cap_en || round_en;
  assign w_cur  = win_q[0];

  generate
    for (genvar j = 0; j < WIN_LEN; j++) begin : g_slot
      if (j == WIN_LEN - 1) begin : g_tail
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     win_q[j] <= '0;
          else if (shift) win_q[j] <= cap_en ? cap_word : next_w;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)     win_q[j] <= '0;
          else if (shift) win_q[j] <= win_q[j+1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/sha_round_core.sv
module sha_round_core
  import sha_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_vars,
  input  logic [DIGEST_W-1:0] hash_in,
  input  logic                round_en,
  input  logic [5:0]          round_idx,
  input  word_t               w_in,
  output logic [DIGEST_W-1:0] vars_out
);

  word_t v_q [HASH_WORDS];
  word_t nxt [HASH_WORDS];
  word_t t1;
  word_t t2;

  assign t1 = v_q[7] + big_sig1(v_q[4]) + choose(v_q[4], v_q[5], v_q[6])
            + round_k(round_idx) + w_in;
  assign t2 = big_sig0(v_q[0]) + majority(v_q[0], v_q[1], v_q[2]);

  always_comb begin
    nxt[0] = t1 + t2;
    nxt[1] = v_q[0];
    nxt[2] = v_q[1];
    nxt[3] = v_q[2];
    nxt[4] = v_q[3] + t1;
    nxt[5] = v_q[4];
    nxt[6] = v_q[5];
    nxt[7] = v_q[6];
  end

  generate
    for (genvar i = 0; i < HASH_WORDS; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         v_q[i] <= '0;
        else if (load_vars) v_q[i] <= hash_in[DIGEST_W-1-WORD_W*i -: WORD_W];
        else if (round_en)  v_q[i] <= nxt[i];
      end
      assign vars_out[DIGEST_W-1-WORD_W*i -: WORD_W] = v_q[i];
    end
  endgenerate

endmodule

// File: rtl/sha_hash_state.sv
module sha_hash_state
  import sha_eng_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_hash,
  input  logic                add_en,
  input  logic [DIGEST_W-1:0] vars_in,
  output logic [DIGEST_W-1:0] digest
);

  word_t h_q [HASH_WORDS];

  generate
    for (genvar i = 0; i < HASH_WORDS; i++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         h_q[i] <= '0;
        else if (init_hash) h_q[i] <= IV_TAB[i];
        else if (add_en)    h_q[i] <= h_q[i] + vars_in[DIGEST_W-1-WORD_W*i -: WORD_W];
      end
      assign digest[DIGEST_W-1-WORD_W*i -: WORD_W] = h_q[i];
    end
  endgenerate

endmodule

// File: rtl/sha_chunk_engine.sv
module sha_chunk_engine
  import sha_eng_pkg::*;
#(
  parameter int MAX_CHUNKS = 64,
  localparam int CHUNK_W = $clog2(MAX_CHUNKS),
  localparam int CNT_W   = CHUNK_W + 1,
  localparam int ADDR_W  = CHUNK_W + $clog2(WIN_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [CNT_W-1:0]    chunk_count,
  output logic                rd_en,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [WORD_W-1:0]   rd_data,
  output logic                done,
  output logic [DIGEST_W-1:0] digest
);

  // Named internal events, also watched by the bound checker.
  logic                idle_w;
  logic                fetch_done_w;
  logic                round_last_w;
  logic                add_en_w;
  logic                chunk_last_w;
  logic [CNT_W-1:0]    chunks_w;

  logic                cap_en_w;
  logic                load_vars_w;
  logic                round_en_w;
  logic [5:0]          round_idx_w;
  logic                init_hash_w;
  word_t               w_cur_w;
  logic [DIGEST_W-1:0] vars_w;

  sha_eng_ctrl #(.MAX_CHUNKS(MAX_CHUNKS)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .chunk_count(chunk_count),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .cap_en     (cap_en_w),
    .load_vars  (load_vars_w),
    .round_en   (round_en_w),
    .round_idx  (round_idx_w),
    .add_en     (add_en_w),
    .init_hash  (init_hash_w),
    .done       (done),
    .idle       (idle_w),
    .fetch_done (fetch_done_w),
    .round_last (round_last_w),
    .chunk_last (chunk_last_w),
    .chunks_o   (chunks_w)
  );

  sha_msg_sched sched_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (cap_en_w),
    .cap_word(rd_data),
    .round_en(round_en_w),
    .w_cur   (w_cur_w)
  );

  sha_round_core core_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_vars(load_vars_w),
    .hash_in  (digest),
    .round_en (round_en_w),
    .round_idx(round_idx_w),
    .w_in     (w_cur_w),
    .vars_out (vars_w)
  );

  sha_hash_state hstate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_hash(init_hash_w),
    .add_en   (add_en_w),
    .vars_in  (vars_w),
    .digest   (digest)
  );

endmodule

// File: rtl/sha_eng_chk.sv
module sha_eng_chk #(
  parameter int MAX_CHUNKS = 64,
  localparam int CHUNK_W = $clog2(MAX_CHUNKS),
  localparam int CNT_W   = CHUNK_W + 1,
  localparam int ADDR_W  = CHUNK_W + 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [CNT_W-1:0]   chunk_count,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               done,
  input logic [255:0]       digest,
  input logic               idle,
  input logic               round_last,
  input logic               add_en,
  input logic               chunk_last,
  input logic [CNT_W-1:0]   chunks
);

  // R4
  rd_addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1));

  // R4
  rd_addr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> {1'b0, rd_addr} < {chunks, 4'b0000});

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && $past(idle) |-> $stable(digest));

  // R9
  bad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start && (chunk_count == '0 || chunk_count > CNT_W'(MAX_CHUNKS)) |=> idle);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && start |=> $stable(chunks));

  // R5
  add_after_rounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |-> $past(round_last));

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(add_en) && $past(chunk_last));

endmodule

bind sha_chunk_engine sha_eng_chk #(.MAX_CHUNKS(MAX_CHUNKS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .chunk_count(chunk_count),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .done       (done),
  .digest     (digest),
  .idle       (idle_w),
  .round_last (round_last_w),
  .add_en     (add_en_w),
  .chunk_last (chunk_last_w),
  .chunks     (chunks_w)
);

// File: tb/sha_chunk_engine_tb_top.sv
module sha_chunk_engine_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [6:0]   chunk_count = '0;
  logic         rd_en;
  logic [9:0]   rd_addr;
  logic [31:0]  rd_data;
  logic         done;
  logic [255:0] digest;

  always #5 clk = ~clk;

  sha_chunk_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .chunk_count(chunk_count),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .digest(digest)
  );

  localparam logic [255:0] ABC_DIG =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] EMPTY_DIG =
    256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;

  localparam logic [31:0] KC [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  logic [31:0] mem [1024];
  int rd_total = 0;
  int addr_err_total = 0;
  int run_base = 0;
  int cyc = 0;
  bit wd_fired = 1'b0;
  int n_checks = 0;
  int n_fail = 0;

  // Memory model: one cycle of read latency; address order monitor (R4).
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
      if (int'(rd_addr) != rd_total - run_base) addr_err_total++;
      rd_total++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) wd_fired = 1'b1;
  end

  initial begin
    wait (wd_fired);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  // Independent hash model over mem, chunk by chunk.
  function automatic logic [255:0] model_digest(input int n);
    logic [31:0] hh [8];
    logic [31:0] ww [64];
    logic [31:0] a, b, c, d, e, f, g, h, x1, x2;
    hh = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
           32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    for (int ck = 0; ck < n; ck++) begin
      for (int t = 0; t < 16; t++) ww[t] = mem[16*ck + t];
      for (int t = 16; t < 64; t++)
        ww[t] = (rr(ww[t-2], 17) ^ rr(ww[t-2], 19) ^ (ww[t-2] >> 10)) + ww[t-7]
              + (rr(ww[t-15], 7) ^ rr(ww[t-15], 18) ^ (ww[t-15] >> 3)) + ww[t-16];
      a = hh[0]; b = hh[1]; c = hh[2]; d = hh[3];
      e = hh[4]; f = hh[5]; g = hh[6]; h = hh[7];
      for (int t = 0; t < 64; t++) begin
        x1 = h + (rr(e, 6) ^ rr(e, 11) ^ rr(e, 25)) + (g ^ (e & (f ^ g))) + KC[t] + ww[t];
        x2 = (rr(a, 2) ^ rr(a, 13) ^ rr(a, 22)) + ((a & b) | (c & (a | b)));
        h = g; g = f; f = e; e = d + x1;
        d = c; c = b; b = a; a = x1 + x2;
      end
      hh[0] += a; hh[1] += b; hh[2] += c; hh[3] += d;
      hh[4] += e; hh[5] += f; hh[6] += g; hh[7] += h;
    end
    return {hh[0], hh[1], hh[2], hh[3], hh[4], hh[5], hh[6], hh[7]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load_abc();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0]  = 32'h61626380;
    mem[15] = 32'h00000018;
  endtask

  task automatic load_empty();
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[0] = 32'h80000000;
  endtask

  task automatic load_pattern(input int n, input logic [31:0] seed);
    for (int i = 0; i < 16*n; i++)
      mem[i] = (32'(i) * 32'h9e3779b9) ^ seed ^ (32'(i) << 20) ^ {seed[15:0], 16'(i)};
  endtask

  int r_lat, r_dones, r_reads, r_aerr;
  logic [255:0] r_dig;
  bit r_hold_ok;

  task automatic run_engine(input logic [6:0] cnt, input int stray_at, input int limit);
    int n;
    int ab;
    @(negedge clk);
    n = 0; r_lat = 0; r_dones = 0;
    run_base = rd_total; ab = addr_err_total; r_dig = digest;
    start = 1'b1; chunk_count = cnt;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (n == 1) start = 1'b0;
      if (stray_at > 0 && n == stray_at) begin start = 1'b1; chunk_count = 7'd5; end
      if (stray_at > 0 && n == stray_at + 1) start = 1'b0;
      if (done) begin
        r_dones++;
        if (r_lat == 0) begin r_lat = n; r_dig = digest; end
      end
      if (r_lat != 0 && n >= r_lat + 3) break;
    end
    r_reads = rd_total - run_base;
    r_aerr = addr_err_total - ab;
    r_hold_ok = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (digest !== r_dig || done) r_hold_ok = 1'b0;
    end
  endtask

  task automatic check_run(input int n, input logic [255:0] expd, input string req);
    chk(r_dig === expd, req, "digest", r_dig, expd);
    chk(r_lat == 82*n + 1, "R5", "done latency", 256'(r_lat), 256'(82*n + 1));
    chk(r_dones == 1, "R6", "done pulse count", 256'(r_dones), 256'd1);
    chk(r_reads == 16*n, "R4", "read count", 256'(r_reads), 256'(16*n));
    chk(r_aerr == 0, "R4", "address order errors", 256'(r_aerr), 256'd0);
    chk(r_hold_ok, "R7", "digest hold after done", 256'(r_hold_ok), 256'd1);
  endtask

  initial begin
    logic [255:0] e;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", 256'(done), 256'd0);
    chk(rd_en == 1'b0, "R1", "rd_en in reset", 256'(rd_en), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(digest === '0, "R1", "digest after reset", digest, '0);

    // R2: known one-block vectors
    load_abc();
    chk(model_digest(1) === ABC_DIG, "R2", "bench model sanity", model_digest(1), ABC_DIG);
    run_engine(7'd1, 0, 200);
    check_run(1, ABC_DIG, "R2");
    load_empty();
    run_engine(7'd1, 0, 200);
    check_run(1, EMPTY_DIG, "R2");

    // R3: chained chunks
    for (int k = 2; k <= 4; k++) begin
      load_pattern(k, 32'h5a5a0000 + 32'(k));
      e = model_digest(k);
      run_engine(7'(k), 0, 82*k + 20);
      check_run(k, e, "R3");
    end

    // R10: rerun after a multi-chunk message restarts from the initial values
    load_abc();
    run_engine(7'd1, 0, 200);
    check_run(1, ABC_DIG, "R10");

    // R8: stray start mid-run is ignored
    load_pattern(2, 32'hc0ffee11);
    e = model_digest(2);
    run_engine(7'd2, 40, 200);
    check_run(2, e, "R8");

    // R9: counts 0 and 65 are ignored
    e = digest;
    run_engine(7'd0, 0, 300);
    chk(r_lat == 0 && r_dones == 0, "R9", "done on zero count", 256'(r_dones), 256'd0);
    chk(r_reads == 0, "R9", "reads on zero count", 256'(r_reads), 256'd0);
    chk(r_hold_ok && digest === e, "R9", "digest on zero count", digest, e);
    run_engine(7'd65, 0, 300);
    chk(r_dones == 0, "R9", "done on count 65", 256'(r_dones), 256'd0);
    chk(r_reads == 0, "R9", "reads on count 65", 256'(r_reads), 256'd0);
    chk(digest === e, "R9", "digest on count 65", digest, e);

    // R3: full-size message reaching the top address
    load_pattern(64, 32'h13572468);
    e = model_digest(64);
    run_engine(7'd64, 0, 82*64 + 20);
    check_run(64, e, "R3");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule